// File: doc/BRIEF.md
# Receive Message Ring with Movable Base

This block is the message store between a CAN protocol engine and a host CPU. The engine writes frames into a 64-byte circular RAM one byte per cycle. It marks the last byte of each frame and tags every frame as received, transmitted, or transmitted with a self-reception request. Received frames and self-reception frames become pending messages. A pending message raises the receive interrupt until the CPU releases it.

A plain transmitted frame is still copied into the RAM just past the pending messages. The CPU can read it there, but it is never counted, and the next frame written overwrites it.

The CPU reads the oldest pending message through a read window addressed by an offset from the base register. A release command moves the base past that message. Two resets act differently. The asynchronous hardware reset puts the base at address 0. The synchronous soft reset, used on entry to reset mode or on bus-off, empties the ring at the base it already has. Neither reset clears the RAM.

Top module: `rcv_ring_buf`

## Requirements
- R1: While `rst_ni` is low, `sa_o` is 0, `msg_cnt_o` is 0, `rx_irq_o` is 0 and `ovr_o` is 0.
- R2: A frame tagged as received (`wr_tx_i`=0 on its last byte) that fits is committed on the edge that takes its last byte. From the next cycle `msg_cnt_o` is one higher and `rx_irq_o` is 1. `msg_cnt_o` changes by at most one per cycle except on soft reset.
- R3: `rd_data_o` is combinational and shows the RAM byte at address (`sa_o` + `rd_off_i`) mod 64. Offsets 0..L-1 return the L bytes of the oldest pending message in arrival order.
- R4: A frame with `wr_tx_i`=1 and `wr_self_i`=0 is written at the write position just past the pending messages and leaves `msg_cnt_o` and `rx_irq_o` unchanged. The next frame is written over it from the same position.
- R5: A frame with `wr_tx_i`=1 and `wr_self_i`=1 is counted exactly like a received frame.
- R6: `release_i` with at least one pending message advances `sa_o` by that message's length mod 64 and lowers `msg_cnt_o` by one. `rx_irq_o` drops when the count reaches 0. `sa_o` changes on no other event except `sa_we_i`.
- R7: `release_i` with no pending message leaves `sa_o` and `msg_cnt_o` unchanged.
- R8: A cycle of `soft_rst_i` clears `msg_cnt_o`, `rx_irq_o` and `ovr_o` and keeps `sa_o`. The next frame is written starting at offset 0 from `sa_o`.
- R9: Neither reset alters the RAM. Old bytes stay readable through `rd_off_i` afterwards.
- R10: A byte that finds all 64 bytes occupied is dropped together with the rest of its frame. No message is committed, and `ovr_o` is set. `ovr_o` stays set until `clr_ovr_i` or a reset.
- R11: A countable frame that completes while 16 messages are pending is dropped, and `ovr_o` is set. `msg_cnt_o` never exceeds 16.
- R12: Write and read addresses wrap modulo 64. A message that crosses address 63 reads back intact.
- R13: `sa_we_i` loads `sa_o` from `sa_wdata_i` on the next edge. On an empty ring the next frame lands at offset 0 from the new base.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low hardware reset |
| soft_rst_i | input | 1 | Synchronous ring reset (reset mode entry or bus-off) |
| wr_valid_i | input | 1 | Byte from the protocol engine is valid |
| wr_data_i | input | 8 | Byte from the protocol engine |
| wr_last_i | input | 1 | Marks the last byte of a frame |
| wr_tx_i | input | 1 | Frame is being transmitted by this node |
| wr_self_i | input | 1 | Transmission was requested with self-reception |
| rd_off_i | input | 6 | CPU read offset from the base |
| rd_data_o | output | 8 | Byte at base plus offset |
| release_i | input | 1 | Release the oldest pending message |
| sa_we_i | input | 1 | Write strobe for the base register |
| sa_wdata_i | input | 6 | New base value |
| sa_o | output | 6 | Current base (start of the oldest message) |
| clr_ovr_i | input | 1 | Clear the overrun flag |
| ovr_o | output | 1 | Overrun flag |
| msg_cnt_o | output | 5 | Number of pending messages |
| rx_irq_o | output | 1 | Receive interrupt, high while messages are pending |

## Verification
The bench mirrors a plain transmitted frame into a ring that already holds a message, then follows it with a received frame. A design that advanced the write position on transmit would leave a gap and misplace the next message, and one that counted the frame would raise the interrupt. It issues a hardware reset and a soft reset while the base is nonzero and reads stale bytes afterwards, which catches a base forced to zero by the wrong reset or a RAM that gets wiped. It fills the ring exactly to 64 bytes across the wrap point, offers a frame that only partly fits, and separately exceeds the 16-message limit. An off-by-one fill test would accept the extra byte or corrupt the wrapped messages, and a missing limit would push the count to 17. A release on an empty ring must not move the base, and a self-reception frame must count.

// File: rtl/rcv_ring_pkg.sv
package rcv_ring_pkg;
  localparam int unsigned BYTE_W = 8;

  // a transmitted frame only counts when self-reception was requested
  function automatic logic counts_as_rx(input logic from_tx, input logic self_rx);
    return ~from_tx | self_rx;
  endfunction
endpackage

// File: rtl/rcv_ring_ram.sv
module rcv_ring_ram #(
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem_q [DEPTH];

  // no reset: contents survive both reset kinds
  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/rcv_len_ring.sv
module rcv_len_ring #(
  parameter int unsigned MSG_DEPTH = 16,
  parameter int unsigned LEN_W     = 7
) (
  input  logic                               clk_i,
  input  logic                               rst_ni,
  input  logic                               clr_i,
  input  logic                               push_i,
  input  logic [LEN_W-1:0]                   push_len_i,
  input  logic                               pop_i,
  output logic [LEN_W-1:0]                   head_len_o,
  output logic [$clog2(MSG_DEPTH+1)-1:0]     cnt_o,
  output logic                               full_o
);
  localparam int unsigned PTR_W = (MSG_DEPTH > 1) ? $clog2(MSG_DEPTH) : 1;
  localparam int unsigned CNT_W = $clog2(MSG_DEPTH + 1);

  logic [LEN_W-1:0] len_q [MSG_DEPTH];
  logic [PTR_W-1:0] wptr_q, rptr_q;
  logic [CNT_W-1:0] cnt_q;

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(MSG_DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i) begin
    if (push_i) len_q[wptr_q] <= push_len_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else if (clr_i) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (push_i) wptr_q <= ptr_inc(wptr_q);
      if (pop_i)  rptr_q <= ptr_inc(rptr_q);
      case ({push_i, pop_i})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assign head_len_o = len_q[rptr_q];
  assign cnt_o      = cnt_q;
  assign full_o     = (cnt_q == CNT_W'(MSG_DEPTH));
endmodule

// File: rtl/rcv_ring_ctrl.sv
module rcv_ring_ctrl
  import rcv_ring_pkg::*;
#(
  parameter int unsigned ADDR_W    = 6,
  parameter int unsigned MSG_DEPTH = 16
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           soft_rst_i,
  input  logic                           wr_valid_i,
  input  logic                           wr_last_i,
  input  logic                           wr_tx_i,
  input  logic                           wr_self_i,
  input  logic                           release_i,
  input  logic                           sa_we_i,
  input  logic [ADDR_W-1:0]              sa_wdata_i,
  input  logic                           clr_ovr_i,
  input  logic [ADDR_W-1:0]              rd_off_i,
  input  logic [ADDR_W:0]                head_len_i,
  input  logic [$clog2(MSG_DEPTH+1)-1:0] ring_cnt_i,
  input  logic                           ring_full_i,
  output logic                           ram_we_o,
  output logic [ADDR_W-1:0]              ram_waddr_o,
  output logic [ADDR_W-1:0]              ram_raddr_o,
  output logic                           push_o,
  output logic [ADDR_W:0]                push_len_o,
  output logic                           pop_o,
  output logic                           ring_clr_o,
  output logic [ADDR_W-1:0]              sa_o,
  output logic                           ovr_o
);
  localparam int unsigned DEPTH = 1 << ADDR_W;
  localparam int unsigned LEN_W = ADDR_W + 1;

  logic [ADDR_W-1:0] sa_q;
  logic [LEN_W-1:0]  used_q;   // bytes held by pending messages
  logic [LEN_W-1:0]  stage_q;  // bytes of the frame in flight
  logic              drop_q;
  logic              ovr_q;

  logic [LEN_W:0]    fill;
  logic              space_ok, byte_try, byte_acc, byte_ovf;
  logic              frame_end, counted, rec_full, frame_bad, commit, rel;
  logic              ovr_set;
  logic [LEN_W-1:0]  frame_len;

  always_comb begin
    fill      = {1'b0, used_q} + {1'b0, stage_q};
    space_ok  = fill < (LEN_W+1)'(DEPTH);
    byte_try  = wr_valid_i & ~drop_q & ~soft_rst_i;
    byte_acc  = byte_try & space_ok;
    byte_ovf  = byte_try & ~space_ok;
    frame_end = wr_valid_i & wr_last_i & ~soft_rst_i;
    frame_len = stage_q + LEN_W'(byte_acc);
    counted   = counts_as_rx(wr_tx_i, wr_self_i);
    rec_full  = counted & ring_full_i;
    frame_bad = drop_q | byte_ovf | rec_full;
    commit    = frame_end & counted & ~frame_bad;
    rel       = release_i & (ring_cnt_i != '0) & ~soft_rst_i;
    ovr_set   = byte_ovf | (frame_end & rec_full);
  end

  assign ram_we_o    = byte_acc;
  assign ram_waddr_o = sa_q + used_q[ADDR_W-1:0] + stage_q[ADDR_W-1:0];
  assign ram_raddr_o = sa_q + rd_off_i;
  assign push_o      = commit;
  assign push_len_o  = frame_len;
  assign pop_o       = rel;
  assign ring_clr_o  = soft_rst_i;
  assign sa_o        = sa_q;
  assign ovr_o       = ovr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      used_q  <= '0;
      stage_q <= '0;
      drop_q  <= 1'b0;
      ovr_q   <= 1'b0;
    end else if (soft_rst_i) begin
      used_q  <= '0;
      stage_q <= '0;
      drop_q  <= 1'b0;
      ovr_q   <= 1'b0;
    end else begin
      used_q <= used_q + (commit ? frame_len : '0) - (rel ? head_len_i : '0);
      if (frame_end) begin
        stage_q <= '0;
        drop_q  <= 1'b0;
      end else begin
        if (byte_acc) stage_q <= stage_q + 1'b1;
        if (byte_ovf) drop_q  <= 1'b1;
      end
      if (ovr_set)        ovr_q <= 1'b1;
      else if (clr_ovr_i) ovr_q <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      sa_q <= '0;
    else if (sa_we_i) sa_q <= sa_wdata_i;
    else if (rel)     sa_q <= sa_q + head_len_i[ADDR_W-1:0];
  end
endmodule

// File: rtl/rcv_ring_buf.sv
module rcv_ring_buf
  import rcv_ring_pkg::*;
#(
  parameter int unsigned ADDR_W    = 6,
  parameter int unsigned MSG_DEPTH = 16,
  parameter int unsigned DATA_W    = BYTE_W
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           soft_rst_i,
  input  logic                           wr_valid_i,
  input  logic [DATA_W-1:0]              wr_data_i,
  input  logic                           wr_last_i,
  input  logic                           wr_tx_i,
  input  logic                           wr_self_i,
  input  logic [ADDR_W-1:0]              rd_off_i,
  output logic [DATA_W-1:0]              rd_data_o,
  input  logic                           release_i,
  input  logic                           sa_we_i,
  input  logic [ADDR_W-1:0]              sa_wdata_i,
  output logic [ADDR_W-1:0]              sa_o,
  input  logic                           clr_ovr_i,
  output logic                           ovr_o,
  output logic [$clog2(MSG_DEPTH+1)-1:0] msg_cnt_o,
  output logic                           rx_irq_o
);
  localparam int unsigned LEN_W = ADDR_W + 1;
  localparam int unsigned CNT_W = $clog2(MSG_DEPTH + 1);

  logic              ram_we;
  logic [ADDR_W-1:0] ram_waddr, ram_raddr;
  logic              push, pop, ring_clr, ring_full;
  logic [LEN_W-1:0]  push_len, head_len;
  logic [CNT_W-1:0]  ring_cnt;

  rcv_ring_ctrl #(.ADDR_W(ADDR_W), .MSG_DEPTH(MSG_DEPTH)) i_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .soft_rst_i  (soft_rst_i),
    .wr_valid_i  (wr_valid_i),
    .wr_last_i   (wr_last_i),
    .wr_tx_i     (wr_tx_i),
    .wr_self_i   (wr_self_i),
    .release_i   (release_i),
    .sa_we_i     (sa_we_i),
    .sa_wdata_i  (sa_wdata_i),
    .clr_ovr_i   (clr_ovr_i),
    .rd_off_i    (rd_off_i),
    .head_len_i  (head_len),
    .ring_cnt_i  (ring_cnt),
    .ring_full_i (ring_full),
    .ram_we_o    (ram_we),
    .ram_waddr_o (ram_waddr),
    .ram_raddr_o (ram_raddr),
    .push_o      (push),
    .push_len_o  (push_len),
    .pop_o       (pop),
    .ring_clr_o  (ring_clr),
    .sa_o        (sa_o),
    .ovr_o       (ovr_o)
  );

  rcv_ring_ram #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_ram (
    .clk_i   (clk_i),
    .we_i    (ram_we),
    .waddr_i (ram_waddr),
    .wdata_i (wr_data_i),
    .raddr_i (ram_raddr),
    .rdata_o (rd_data_o)
  );

  rcv_len_ring #(.MSG_DEPTH(MSG_DEPTH), .LEN_W(LEN_W)) i_len (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (ring_clr),
    .push_i     (push),
    .push_len_i (push_len),
    .pop_i      (pop),
    .head_len_o (head_len),
    .cnt_o      (ring_cnt),
    .full_o     (ring_full)
  );

  assign msg_cnt_o = ring_cnt;
  assign rx_irq_o  = (ring_cnt != '0);
endmodule

// File: rtl/rcv_ring_buf_chk.sv
module rcv_ring_buf_chk #(
  parameter int unsigned ADDR_W    = 6,
  parameter int unsigned MSG_DEPTH = 16
) (
  input logic                           clk_i,
  input logic                           rst_ni,
  input logic                           soft_rst_i,
  input logic                           wr_valid_i,
  input logic                           wr_last_i,
  input logic                           wr_tx_i,
  input logic                           wr_self_i,
  input logic                           release_i,
  input logic                           sa_we_i,
  input logic [ADDR_W-1:0]              sa_wdata_i,
  input logic [ADDR_W-1:0]              sa_o,
  input logic                           clr_ovr_i,
  input logic                           ovr_o,
  input logic [$clog2(MSG_DEPTH+1)-1:0] msg_cnt_o,
  input logic                           rx_irq_o
);
  localparam int unsigned CNT_W = $clog2(MSG_DEPTH + 1);

  p_irq_follows_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (msg_cnt_o != '0) |-> rx_irq_o);

  p_cnt_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !soft_rst_i |=> (msg_cnt_o == $past(msg_cnt_o)) ||
                    (msg_cnt_o == $past(msg_cnt_o) + 1'b1) ||
                    (msg_cnt_o == $past(msg_cnt_o) - 1'b1));

  p_tx_plain_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_valid_i && wr_last_i && wr_tx_i && !wr_self_i && !release_i && !soft_rst_i)
    |=> msg_cnt_o == $past(msg_cnt_o));

  p_rel_dec_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (release_i && msg_cnt_o != '0 && !soft_rst_i && !(wr_valid_i && wr_last_i))
    |=> msg_cnt_o == $past(msg_cnt_o) - 1'b1);

  p_sa_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!release_i && !sa_we_i) |=> $stable(sa_o));

  p_empty_rel_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (release_i && msg_cnt_o == '0 && !sa_we_i) |=> $stable(sa_o));

  p_soft_clear_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (soft_rst_i && !sa_we_i) |=> (msg_cnt_o == '0) && !ovr_o && $stable(sa_o));

  p_ovr_sticky_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovr_o && !clr_ovr_i && !soft_rst_i) |=> ovr_o);

  p_cnt_limit_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    msg_cnt_o <= CNT_W'(MSG_DEPTH));

  p_sa_load_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sa_we_i |=> sa_o == $past(sa_wdata_i));
endmodule

bind rcv_ring_buf rcv_ring_buf_chk #(.ADDR_W(ADDR_W), .MSG_DEPTH(MSG_DEPTH)) i_chk (.*);

// File: tb/test_rcv_ring_buf.sv
`timescale 1ns/1ps
module test_rcv_ring_buf;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       soft_rst_i = 1'b0;
  logic       wr_valid_i = 1'b0;
  logic [7:0] wr_data_i = '0;
  logic       wr_last_i = 1'b0;
  logic       wr_tx_i = 1'b0;
  logic       wr_self_i = 1'b0;
  logic [5:0] rd_off_i = '0;
  logic [7:0] rd_data_o;
  logic       release_i = 1'b0;
  logic       sa_we_i = 1'b0;
  logic [5:0] sa_wdata_i = '0;
  logic [5:0] sa_o;
  logic       clr_ovr_i = 1'b0;
  logic       ovr_o;
  logic [4:0] msg_cnt_o;
  logic       rx_irq_o;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  // scoreboard model
  int len_q[$];
  int byte_q[$];
  int exp_sa = 0;
  int exp_used = 0;
  int exp_ovr = 0;

  always #4 clk_i = ~clk_i;

  rcv_ring_buf i_rcv_ring_buf (.*);

  task automatic chk(input int act, input int exp, input string req, input string what);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic chk_state(input string req);
    chk(int'(msg_cnt_o), len_q.size(), req, "msg_cnt");
    chk(int'(rx_irq_o), int'(len_q.size() != 0), req, "rx_irq");
    chk(int'(ovr_o), exp_ovr, req, "ovr");
    chk(int'(sa_o), exp_sa, req, "sa");
  endtask

  task automatic read_at(input int off, output int val);
    @(negedge clk_i);
    rd_off_i = 6'(off);
    #1;
    val = int'(rd_data_o);
  endtask

  // driver: streams a frame and pushes what the requirements predict
  task automatic send_frame(input int len, input int base, input bit tx, input bit self_rx);
    bit counted;
    counted = !tx || self_rx;
    for (int i = 0; i < len; i++) begin
      @(negedge clk_i);
      wr_valid_i = 1'b1;
      wr_data_i  = 8'((base + i) & 255);
      wr_last_i  = (i == len - 1);
      wr_tx_i    = tx;
      wr_self_i  = self_rx;
    end
    @(negedge clk_i);
    wr_valid_i = 1'b0;
    wr_last_i  = 1'b0;
    wr_tx_i    = 1'b0;
    wr_self_i  = 1'b0;
    if (exp_used + len > 64) exp_ovr = 1;
    else if (counted) begin
      if (len_q.size() == 16) exp_ovr = 1;
      else begin
        len_q.push_back(len);
        for (int i = 0; i < len; i++) byte_q.push_back((base + i) & 255);
        exp_used += len;
      end
    end
  endtask

  // monitor: pops the oldest expected message, compares, releases it
  task automatic drain_head(input string req);
    int l, v;
    if (len_q.size() == 0) begin
      chk(0, 1, req, "scoreboard empty on drain");
      return;
    end
    l = len_q.pop_front();
    for (int i = 0; i < l; i++) begin
      read_at(i, v);
      chk(v, byte_q.pop_front(), req, "message byte");
    end
    @(negedge clk_i);
    release_i = 1'b1;
    @(negedge clk_i);
    release_i = 1'b0;
    exp_sa = (exp_sa + l) % 64;
    exp_used -= l;
    chk(int'(sa_o), exp_sa, "R6", "sa after release");
    chk(int'(msg_cnt_o), len_q.size(), "R6", "msg_cnt after release");
  endtask

  task automatic pulse_soft;
    @(negedge clk_i);
    soft_rst_i = 1'b1;
    @(negedge clk_i);
    soft_rst_i = 1'b0;
    len_q.delete();
    byte_q.delete();
    exp_used = 0;
    exp_ovr = 0;
  endtask

  task automatic pulse_clr_ovr;
    @(negedge clk_i);
    clr_ovr_i = 1'b1;
    @(negedge clk_i);
    clr_ovr_i = 1'b0;
    exp_ovr = 0;
  endtask

  initial begin
    int v;
    repeat (3) @(negedge clk_i);
    chk_state("R1");
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R2 received frame
    send_frame(5, 8'h10, 0, 0);
    chk_state("R2");
    // R4 plain tx mirrored after pending message, not counted
    send_frame(3, 8'hA0, 1, 0);
    chk_state("R4");
    read_at(5, v); chk(v, 8'hA0, "R4", "mirrored tx byte 0");
    read_at(7, v); chk(v, 8'hA2, "R4", "mirrored tx byte 2");
    send_frame(4, 8'h20, 0, 0);
    read_at(5, v); chk(v, 8'h20, "R4", "next frame overwrites tx");
    // R5 self-reception counts
    send_frame(2, 8'h30, 1, 1);
    chk_state("R5");
    drain_head("R3");

    // R1 hardware reset mid-run, R9 RAM kept
    @(negedge clk_i);
    rst_ni = 1'b0;
    #1;
    chk(int'(sa_o), 0, "R1", "sa during reset");
    chk(int'(msg_cnt_o), 0, "R1", "msg_cnt during reset");
    chk(int'(rx_irq_o), 0, "R1", "rx_irq during reset");
    @(negedge clk_i);
    rst_ni = 1'b1;
    len_q.delete(); byte_q.delete();
    exp_sa = 0; exp_used = 0; exp_ovr = 0;
    read_at(0, v); chk(v, 8'h10, "R9", "stale byte after hw reset");
    read_at(5, v); chk(v, 8'h20, "R9", "stale byte 5 after hw reset");

    // R8 soft reset keeps base
    send_frame(6, 8'h40, 0, 0);
    send_frame(6, 8'h48, 0, 0);
    drain_head("R3");
    pulse_soft();
    chk_state("R8");
    read_at(0, v); chk(v, 8'h48, "R9", "stale byte after soft reset");
    send_frame(3, 8'h60, 0, 0);
    read_at(0, v); chk(v, 8'h60, "R8", "frame lands at base after soft reset");
    drain_head("R8");

    // R12 wrap, R10 overrun
    for (int k = 0; k < 8; k++) send_frame(8, 8'h80 + 8 * k, 0, 0);
    chk_state("R12");
    send_frame(2, 8'hF0, 0, 0);
    chk_state("R10");
    pulse_clr_ovr();
    chk(int'(ovr_o), 0, "R10", "ovr cleared");
    drain_head("R12");
    send_frame(10, 8'hC0, 0, 0);
    chk_state("R10");
    chk(exp_ovr, 1, "R10", "model overrun on partial frame");
    send_frame(4, 8'hD0, 0, 0);
    chk_state("R10");
    while (len_q.size() != 0) drain_head("R12");
    pulse_clr_ovr();

    // R11 message record limit
    for (int k = 0; k < 16; k++) send_frame(1, k, 0, 0);
    chk_state("R11");
    send_frame(1, 8'h55, 0, 0);
    chk_state("R11");
    pulse_clr_ovr();
    while (len_q.size() != 0) drain_head("R11");

    // R7 release on empty ring
    @(negedge clk_i);
    release_i = 1'b1;
    @(negedge clk_i);
    release_i = 1'b0;
    chk_state("R7");

    // R13 base write
    @(negedge clk_i);
    sa_we_i = 1'b1;
    sa_wdata_i = 6'd40;
    @(negedge clk_i);
    sa_we_i = 1'b0;
    exp_sa = 40;
    chk_state("R13");
    send_frame(2, 8'h77, 0, 0);
    read_at(0, v); chk(v, 8'h77, "R13", "frame at new base");
    drain_head("R13");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule